// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This controller gathers thirteen level-sensitive request lines and presents at most one of them to a processor core. The request it presents is a 16-bit vector address. Each source has its own enable bit, and one global enable bit gates every source. Each source can be set to a high or a low level. Within a level, a fixed natural order settles ties.

Two in-service bits, one per level, record which handlers are running. A high-level request can interrupt a low-level handler. A request at the same or a lower level is held back until the core signals a return from interrupt. The request lines are expected to stay asserted until software clears the flag behind them. The core itself is outside the block.

Top module: `intc_vec_ctrl`

## Requirements
- R1: Source slot s (0 ext-int 0, 1 timer 0, 2 ext-int 1, 3 timer 1, 4 serial 0, 5 timer 2, 6 resume, 7 serial 1, 8 USB, 9 I2C, 10 ext-int 4, 11 ext-int 5, 12 ext-int 6) is presented with vector 0x0003 + 8*s.
- R2: While `ien_base[7]` (the global enable) is 0, `irq_out` stays 0 whatever the requests are.
- R3: A source is considered only when its enable bit is 1. The enable bits are mapped as follows. `ien_base` bits 0..5 enable slots 0..5, bit 6 enables slot 7, and `wake_en` enables slot 6. `ien_ext` bit k enables slot 8+k.
- R4: A source is high level when its priority bit is 1. `ipri_base` and `ipri_ext` use the same bit layout as the enables, and `wake_pri` sets the level of slot 6. Any presentable high-level request wins over every low-level request.
- R5: Within one level, the natural order from strongest to weakest is: slot 6, then slots 0,1,2,3,4,5,7,8,9,10,11,12.
- R6: While the high in-service bit is set, nothing is presented. While only the low in-service bit is set, only high-level requests are presented.
- R7: A cycle with `cpu_ack`=1 and `irq_out`=1 sets the in-service bit of the level being presented. `cpu_ack` while `irq_out`=0 changes nothing.
- R8: A cycle with `cpu_reti`=1 clears the high in-service bit if it is set, and otherwise clears the low one. When `cpu_ack` and `cpu_reti` fall in the same cycle, the clear takes effect before the set.
- R9: Reset clears both in-service bits. The vector output is purely combinational, so a pending enabled request is presented during reset and in the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 13 | Request lines, indexed by slot |
| ien_base | input | 8 | Global enable (bit 7) and base source enables |
| ien_ext | input | 5 | Extended source enables, slots 8..12 |
| wake_en | input | 1 | Resume source enable |
| ipri_base | input | 7 | Base source priority bits |
| ipri_ext | input | 5 | Extended source priority bits |
| wake_pri | input | 1 | Resume source priority |
| cpu_ack | input | 1 | Core accepts the presented vector |
| cpu_reti | input | 1 | Core returns from a handler |
| irq_out | output | 1 | Interrupt request to the core |
| irq_vector | output | 16 | Vector address of the presented source |

## Verification
The in-service bits are the only state, and each one is visible at the ports as soon as it exists. An in-service bit wrongly set shows up in the next cycle: a pending request that should be presented disappears from `irq_out`. A bit wrongly left clear shows up as a same-level request that reappears one cycle after it was acknowledged. If `cpu_reti` clears the wrong level, the error shows up in the cycle after the return. Either low-level requests come back while the high handler is still marked, or high requests are blocked. The reference model steps those bits every clock, so such a divergence is flagged within one cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int unsigned SLOT_COUNT = 13;

   typedef enum logic [3:0] {
      SL_XI0  = 4'd0,
      SL_TM0  = 4'd1,
      SL_XI1  = 4'd2,
      SL_TM1  = 4'd3,
      SL_SER0 = 4'd4,
      SL_TM2  = 4'd5,
      SL_WAKE = 4'd6,
      SL_SER1 = 4'd7,
      SL_USB  = 4'd8,
      SL_I2C  = 4'd9,
      SL_XI4  = 4'd10,
      SL_XI5  = 4'd11,
      SL_XI6  = 4'd12
   } slot_e;

   // rank 0 is the strongest; the wake slot jumps ahead of its vector position
   function automatic int unsigned rank_to_slot(input int unsigned rank);
      if (rank == 0)
         return int'(SL_WAKE);
      else if (rank <= int'(SL_WAKE))
         return rank - 1;
      else
         return rank;
   endfunction

endpackage

// File: rtl/intc_src_map.sv
module intc_src_map
   import intc_pkg::*;
#(
   parameter int unsigned NSRC = 13
) (
   input  logic [NSRC-1:0] src_req,
   input  logic [7:0]      ien_base,
   input  logic [4:0]      ien_ext,
   input  logic            wake_en,
   input  logic [6:0]      ipri_base,
   input  logic [4:0]      ipri_ext,
   input  logic            wake_pri,
   output logic [NSRC-1:0] live_hi,
   output logic [NSRC-1:0] live_lo
);

   localparam int unsigned BASE_LOW = int'(SL_WAKE);
   localparam int unsigned EXT_OFS  = int'(SL_USB);

   logic [NSRC-1:0] en_vec;
   logic [NSRC-1:0] pri_vec;
   logic            global_on;

   assign global_on = ien_base[7];

   always_comb begin
      en_vec  = '0;
      pri_vec = '0;
      for (int unsigned i = 0; i < BASE_LOW; i++) begin
         en_vec[i]  = ien_base[i];
         pri_vec[i] = ipri_base[i];
      end
      en_vec[SL_WAKE]  = wake_en;
      pri_vec[SL_WAKE] = wake_pri;
      en_vec[SL_SER1]  = ien_base[6];
      pri_vec[SL_SER1] = ipri_base[6];
      for (int unsigned k = 0; k < NSRC - EXT_OFS; k++) begin
         en_vec[EXT_OFS+k]  = ien_ext[k];
         pri_vec[EXT_OFS+k] = ipri_ext[k];
      end
   end

   assign live_hi = src_req & en_vec & {NSRC{global_on}} & pri_vec;
   assign live_lo = src_req & en_vec & {NSRC{global_on}} & ~pri_vec;

endmodule

// File: rtl/intc_pick.sv
module intc_pick
   import intc_pkg::*;
#(
   parameter int unsigned NSRC  = 13,
   parameter int unsigned IDX_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]  cand,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   // walk from weakest to strongest so the strongest candidate is written last
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int r = NSRC - 1; r >= 0; r--) begin
         if (cand[rank_to_slot(r)]) begin
            found = 1'b1;
            idx   = IDX_W'(rank_to_slot(r));
         end
      end
   end

endmodule

// File: rtl/intc_inservice.sv
module intc_inservice (
   input  logic clk,
   input  logic rst_n,
   input  logic grant,
   input  logic grant_hi,
   input  logic reti,
   output logic isv_hi,
   output logic isv_lo
);

   logic hi_d;
   logic lo_d;

   always_comb begin
      hi_d = isv_hi;
      lo_d = isv_lo;
      if (reti) begin
         if (isv_hi) hi_d = 1'b0;
         else        lo_d = 1'b0;
      end
      if (grant) begin
         if (grant_hi) hi_d = 1'b1;
         else          lo_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isv_hi <= 1'b0;
         isv_lo <= 1'b0;
      end else begin
         isv_hi <= hi_d;
         isv_lo <= lo_d;
      end
   end

endmodule

// File: rtl/intc_vec_ctrl.sv
module intc_vec_ctrl
   import intc_pkg::*;
#(
   parameter int unsigned NSRC     = 13,
   parameter int unsigned VEC_W    = 16,
   parameter int unsigned VEC_BASE = 3,
   parameter int unsigned VEC_STEP = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_req,
   input  logic [7:0]       ien_base,
   input  logic [4:0]       ien_ext,
   input  logic             wake_en,
   input  logic [6:0]       ipri_base,
   input  logic [4:0]       ipri_ext,
   input  logic             wake_pri,
   input  logic             cpu_ack,
   input  logic             cpu_reti,
   output logic             irq_out,
   output logic [VEC_W-1:0] irq_vector
);

   localparam int unsigned IDX_W   = $clog2(NSRC);
   localparam int unsigned LEVELS  = 2;
   localparam int unsigned VEC_TOP = VEC_BASE + VEC_STEP * (NSRC - 1);

   if (NSRC != SLOT_COUNT) begin : g_bad_count
      $error("intc_vec_ctrl: the slot map is fixed at 13 sources");
   end
   if (VEC_W < 8 || VEC_TOP >= (64'd1 << VEC_W)) begin : g_bad_width
      $error("intc_vec_ctrl: vector width too small for the vector map");
   end

   logic [NSRC-1:0]  live_hi;
   logic [NSRC-1:0]  live_lo;
   logic [NSRC-1:0]  lvl_cand  [LEVELS];
   logic             lvl_found [LEVELS];
   logic [IDX_W-1:0] lvl_idx   [LEVELS];
   logic             isv_hi;
   logic             isv_lo;
   logic             take_hi;
   logic             take_lo;
   logic [IDX_W-1:0] win_idx;

   intc_src_map #(.NSRC(NSRC)) u_map (
      .src_req   (src_req),
      .ien_base  (ien_base),
      .ien_ext   (ien_ext),
      .wake_en   (wake_en),
      .ipri_base (ipri_base),
      .ipri_ext  (ipri_ext),
      .wake_pri  (wake_pri),
      .live_hi   (live_hi),
      .live_lo   (live_lo)
   );

   assign lvl_cand[0] = live_lo;
   assign lvl_cand[1] = live_hi;

   for (genvar g = 0; g < LEVELS; g++) begin : g_level
      intc_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
         .cand  (lvl_cand[g]),
         .found (lvl_found[g]),
         .idx   (lvl_idx[g])
      );
   end

   assign take_hi = lvl_found[1] && !isv_hi;
   assign take_lo = !lvl_found[1] && lvl_found[0] && !isv_hi && !isv_lo;

   assign win_idx    = take_hi ? lvl_idx[1] : lvl_idx[0];
   assign irq_out    = take_hi || take_lo;
   assign irq_vector = irq_out ? VEC_W'(VEC_BASE + VEC_STEP * win_idx) : '0;

   intc_inservice u_isv (
      .clk      (clk),
      .rst_n    (rst_n),
      .grant    (cpu_ack && irq_out),
      .grant_hi (take_hi),
      .reti     (cpu_reti),
      .isv_hi   (isv_hi),
      .isv_lo   (isv_lo)
   );

endmodule

// File: rtl/intc_vec_ctrl_chk.sv
module intc_vec_ctrl_chk #(
   parameter int unsigned VEC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       ien_base,
   input logic             cpu_ack,
   input logic             cpu_reti,
   input logic             irq_out,
   input logic [VEC_W-1:0] irq_vector,
   input logic             isv_hi,
   input logic             isv_lo
);

   p_ea_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ien_base[7] |-> !irq_out);

   p_vec_grid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (irq_vector[2:0] == 3'd3 && irq_vector <= VEC_W'(16'h0063)));

   p_hi_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      isv_hi |-> !irq_out);

   p_ack_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && cpu_ack && !cpu_reti) |=> (isv_hi || isv_lo));

   p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out && cpu_ack && !cpu_reti) |=> ($stable(isv_hi) && $stable(isv_lo)));

   p_reti_drops_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_reti && isv_hi && !cpu_ack) |=> !isv_hi);

   p_reti_keeps_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_reti && isv_hi && isv_lo && !cpu_ack) |=> isv_lo);

endmodule

bind intc_vec_ctrl intc_vec_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ien_base   (ien_base),
   .cpu_ack    (cpu_ack),
   .cpu_reti   (cpu_reti),
   .irq_out    (irq_out),
   .irq_vector (irq_vector),
   .isv_hi     (isv_hi),
   .isv_lo     (isv_lo)
);

// File: tb/sim_intc_vec_ctrl.sv
`timescale 1ns/1ps
module sim_intc_vec_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [12:0] src_req;
   logic [7:0]  ien_base;
   logic [4:0]  ien_ext;
   logic        wake_en;
   logic [6:0]  ipri_base;
   logic [4:0]  ipri_ext;
   logic        wake_pri;
   logic        cpu_ack;
   logic        cpu_reti;
   logic        irq_out;
   logic [15:0] irq_vector;

   int checks = 0;
   int fails  = 0;
   bit m_hi = 1'b0;
   bit m_lo = 1'b0;
   int order [13] = '{6, 0, 1, 2, 3, 4, 5, 7, 8, 9, 10, 11, 12};

   always #5 clk = ~clk;

   intc_vec_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .ien_base(ien_base),
      .ien_ext(ien_ext), .wake_en(wake_en), .ipri_base(ipri_base),
      .ipri_ext(ipri_ext), .wake_pri(wake_pri), .cpu_ack(cpu_ack),
      .cpu_reti(cpu_reti), .irq_out(irq_out), .irq_vector(irq_vector)
   );

   function automatic bit en_of(input int s);
      if (s < 6)       return ien_base[s];
      else if (s == 6) return wake_en;
      else if (s == 7) return ien_base[6];
      else             return ien_ext[s-8];
   endfunction

   function automatic bit pri_of(input int s);
      if (s < 6)       return ipri_base[s];
      else if (s == 6) return wake_pri;
      else if (s == 7) return ipri_base[6];
      else             return ipri_ext[s-8];
   endfunction

   task automatic expect_out(output bit er, output logic [15:0] ev, output bit el);
      int hs = -1;
      int ls = -1;
      for (int r = 0; r < 13; r++) begin
         int s = order[r];
         if (src_req[s] && en_of(s) && ien_base[7]) begin
            if (pri_of(s) && hs < 0) hs = s;
            if (!pri_of(s) && ls < 0) ls = s;
         end
      end
      er = 1'b0; el = 1'b0; ev = 16'h0000;
      if (hs >= 0) begin
         if (!m_hi) begin er = 1'b1; el = 1'b1; ev = 16'(3 + 8 * hs); end
      end else if (ls >= 0 && !m_hi && !m_lo) begin
         er = 1'b1; ev = 16'(3 + 8 * ls);
      end
   endtask

   task automatic cyc(input string tag);
      bit er, el, nh, nl;
      logic [15:0] ev;
      @(negedge clk);
      expect_out(er, ev, el);
      checks++;
      if (irq_out !== er || (er && irq_vector !== ev)) begin
         fails++;
         $display("FAIL %s: irq=%b vec=%h expected irq=%b vec=%h", tag, irq_out, irq_vector, er, ev);
      end
      nh = m_hi; nl = m_lo;
      if (rst_n) begin
         if (cpu_reti) begin
            if (m_hi) nh = 1'b0;
            else      nl = 1'b0;
         end
         if (cpu_ack && er) begin
            if (el) nh = 1'b1;
            else    nl = 1'b1;
         end
      end
      @(posedge clk);
      m_hi = nh; m_lo = nl;
      #1;
   endtask

   task automatic all_on();
      ien_base = 8'hFF; ien_ext = 5'h1F; wake_en = 1'b1;
   endtask

   task automatic all_low();
      ipri_base = '0; ipri_ext = '0; wake_pri = 1'b0;
   endtask

   task automatic en_only(input int s);
      ien_base = 8'h80; ien_ext = '0; wake_en = 1'b0;
      if (s < 6)       ien_base[s] = 1'b1;
      else if (s == 6) wake_en = 1'b1;
      else if (s == 7) ien_base[6] = 1'b1;
      else             ien_ext[s-8] = 1'b1;
   endtask

   task automatic pri_only(input int s);
      all_low();
      if (s < 6)       ipri_base[s] = 1'b1;
      else if (s == 6) wake_pri = 1'b1;
      else if (s == 7) ipri_base[6] = 1'b1;
      else             ipri_ext[s-8] = 1'b1;
   endtask

   task automatic pulse_ack(input string tag);
      cpu_ack = 1'b1; cyc(tag); cpu_ack = 1'b0;
   endtask

   task automatic pulse_reti(input string tag);
      cpu_reti = 1'b1; cyc(tag); cpu_reti = 1'b0;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cpu_ack = 1'b0; cpu_reti = 1'b0;
      src_req = '0; ien_base = '0; ien_ext = '0; wake_en = 1'b0; all_low();
      cyc("R9");
      // R9: request visible during reset and right after it
      all_on(); src_req = 13'h0008;
      cyc("R9");
      rst_n = 1'b1;
      cyc("R9");

      // R1: each slot alone gives its vector
      for (int s = 0; s < 13; s++) begin
         src_req = 13'(1 << s);
         cyc("R1");
      end

      // R2: global enable off silences everything
      src_req = 13'h1FFF; ien_base[7] = 1'b0;
      cyc("R2");
      cpu_ack = 1'b1; cyc("R7"); cpu_ack = 1'b0;   // R7: ack with no request ignored
      ien_base[7] = 1'b1;
      cyc("R7");

      // R3: enable mapping, one source enabled at a time
      for (int s = 0; s < 13; s++) begin
         en_only(s);
         cyc("R3");
      end
      all_on();

      // R5: natural order inside one level
      cyc("R5");
      src_req = 13'h1FBF; cyc("R5");
      src_req = 13'h1400; cyc("R5");
      src_req = 13'h0880; cyc("R5");

      // R4: priority mapping, one high source against all low
      src_req = 13'h1FFF;
      for (int s = 0; s < 13; s++) begin
         pri_only(s);
         cyc("R4");
      end
      ipri_ext = 5'h18; cyc("R4");
      all_low();

      // R6/R7/R8: nesting
      src_req = 13'h0004;
      pulse_ack("R7");
      cyc("R6");
      src_req = 13'h0104; ipri_ext = 5'h01;
      cyc("R6");
      pulse_ack("R7");
      cyc("R6");
      src_req = 13'h1F04; ipri_ext = 5'h1F;
      cyc("R6");
      pulse_reti("R8");
      cyc("R8");
      src_req = 13'h0004; ipri_ext = '0;
      cyc("R8");
      pulse_reti("R8");
      cyc("R8");
      // same-cycle return and acknowledge
      pulse_ack("R7");
      src_req = 13'h0104; ipri_ext = 5'h01;
      cpu_ack = 1'b1; cpu_reti = 1'b1; cyc("R8");
      cpu_ack = 1'b0; cpu_reti = 1'b0;
      cyc("R8");
      src_req = 13'h0004; ipri_ext = '0;
      cyc("R6");
      pulse_reti("R8");
      cyc("R8");
      src_req = '0;
      cyc("R2");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule